// File: doc/BRIEF.md
# DMA Channel Control Write Filter

This block owns the per-channel control registers of a seven-channel DMA controller, together with the plain per-channel address and length words and one shared channel-enable word. Every control write passes through a filter. The filter clears the bits that the channel does not implement and forces the bits that are fixed. It then compares the result with what the register already holds. A write that changes nothing is dropped.

When a write does change a register, the filter looks at the busy bit. If the busy bit goes from clear to set, the block raises a one-cycle start request, but only when that channel's bit in the shared enable word is set. If the busy bit goes from set to clear, the block raises a one-cycle abort request. The transfer engine, which sits outside this block, reports that a channel has finished through a per-channel done strobe. The strobe clears the busy bit and raises no request. Software reads every register back through a combinational read port.

Address map: channel n occupies a 16-byte slot at 0x80 + 16·n. Within the slot, +0x0 is the address word, +0x4 is the length word, and +0x8 and +0xC both reach the control register. The enable word sits at 0xF0. Any other address reads as zero and ignores writes.

Top module: `dma_ctl_filter`

## Requirements
- R1: After reset every control register reads 0, except channel 6, which reads 0x00000002. The address, length and enable words read 0, and no start or abort request is raised.
- R2: For channels 0 to 5, a control write stores the written value ANDed with 0x71770703.
- R3: For channel 6, a control write stores the written value ANDed with 0x51000002 and then ORed with 0x00000002, so bit 1 is always set.
- R4: A control write whose filtered value equals the stored value leaves the register unchanged and raises no start or abort request. This includes writes that differ only in bits the filter clears.
- R5: A control write that takes bit 24 of channel n from 0 to 1 while bit 4n+3 of the enable word is set raises start_req[n] for exactly the one cycle after the write edge, and raises no request on any other channel.
- R6: A control write that takes bit 24 from 0 to 1 while the channel's enable bit is clear stores the value but raises no start request. Setting the enable bit afterwards does not raise one either.
- R7: A control write that takes bit 24 of channel n from 1 to 0 raises abort_req[n] for the one cycle after the write edge.
- R8: A write to control offset +0xC of a channel slot behaves exactly like a write to +0x8.
- R9: done[n] clears bit 24 of channel n on the next edge and raises neither an abort nor a start request.
- R10: Writes to the address, length and enable words are stored whole, read back unchanged and raise no request.
- R11: When a control write that changes the register coincides with done for the same channel, the written value is stored and the done strobe is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 8 | Write byte address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 8 | Read byte address |
| rd_data | output | 32 | Combinational read data |
| done | input | 7 | Per-channel transfer-finished strobe from the engine |
| start_req | output | 7 | One-cycle start request per channel |
| abort_req | output | 7 | One-cycle abort request per channel |

## Verification
The hardest case to reach is a write that lands on a register whose busy bit was set by software and cleared by the engine, because only that history separates R9 from R7. A further hard case is a changing write that meets a done strobe in the same cycle (R11). The random stimulus reaches these cases by picking data derived from the bench's own model of each register: it toggles the busy bit, repeats the stored value with junk in the cleared bits, and pairs writes with done on the same channel. Interleaved writes to the enable word make each busy-bit rise meet both states of its enable bit.

// File: rtl/dma_flt_pkg.sv
package dma_flt_pkg;
   localparam int unsigned DW       = 32;
   localparam int unsigned BUSY_BIT = 24;
   localparam logic [DW-1:0] STD_MASK = 32'h7177_0703;
   localparam logic [DW-1:0] FRC_MASK = 32'h5100_0002;
   localparam logic [DW-1:0] FRC_SET  = 32'h0000_0002;
   localparam logic [DW-1:0] NO_SET   = 32'h0000_0000;

   // word slot inside a channel window
   typedef enum logic [1:0] {
      SLOT_ADR  = 2'd0,
      SLOT_LEN  = 2'd1,
      SLOT_CTL  = 2'd2,
      SLOT_CTLB = 2'd3
   } slot_e;
endpackage

// File: rtl/dma_flt_decode.sv
module dma_flt_decode
   import dma_flt_pkg::*;
#(
   parameter int unsigned AW   = 8,
   parameter int unsigned NCH  = 7,
   parameter int unsigned CHW  = 3,
   parameter logic [AW-1:0] BASE    = 8'h80,
   parameter logic [AW-1:0] EN_ADDR = 8'hF0
) (
   input  logic [AW-1:0]  addr,
   output logic           ch_hit,
   output logic [CHW-1:0] ch_idx,
   output slot_e          slot,
   output logic           en_hit
);
   localparam logic [AW-5:0] NCH_L = (AW-4)'(NCH);

   logic [AW-3:0] offw;
   logic [AW-5:0] blk;

   assign offw   = addr[AW-1:2] - BASE[AW-1:2];
   assign blk    = offw[AW-3:2];
   assign slot   = slot_e'(offw[1:0]);
   assign ch_idx = blk[CHW-1:0];
   assign ch_hit = (addr >= BASE) && (blk < NCH_L) && (addr[1:0] == 2'b00);
   assign en_hit = (addr == EN_ADDR);

   if (AW < CHW + 4) begin : g_bad_aw
      $error("address width too small for channel count");
   end
endmodule

// File: rtl/dma_flt_chan.sv
module dma_flt_chan
   import dma_flt_pkg::*;
#(
   parameter logic [DW-1:0] MASK  = STD_MASK,
   parameter logic [DW-1:0] FORCE = NO_SET
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_i,
   input  logic [DW-1:0] wdata_i,
   input  logic          en_i,
   input  logic          done_i,
   output logic [DW-1:0] ctrl_o,
   output logic          start_o,
   output logic          abort_o
);
   logic [DW-1:0] ctrl_q;
   logic [DW-1:0] filt;
   logic          changed, rise, fall;

   assign filt    = (wdata_i & MASK) | FORCE;
   assign changed = (filt != ctrl_q);
   assign rise    = changed && !ctrl_q[BUSY_BIT] &&  filt[BUSY_BIT];
   assign fall    = changed &&  ctrl_q[BUSY_BIT] && !filt[BUSY_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q  <= FORCE;
         start_o <= 1'b0;
         abort_o <= 1'b0;
      end else begin
         start_o <= wr_i && rise && en_i;
         abort_o <= wr_i && fall;
         if (wr_i && changed)
            ctrl_q <= filt;
         else if (done_i)
            ctrl_q[BUSY_BIT] <= 1'b0;
      end
   end

   assign ctrl_o = ctrl_q;

   // R5: a start follows a write with the enable bit set and leaves busy set
   a_r5_start_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
      start_o |-> (ctrl_q[BUSY_BIT] && $past(wr_i) && $past(en_i)));
   // R7: an abort follows a write and leaves busy clear
   a_r7_abort_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
      abort_o |-> (!ctrl_q[BUSY_BIT] && $past(wr_i)));
   // R9: a done strobe alone clears busy quietly
   a_r9_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (done_i && !wr_i) |=> (!ctrl_q[BUSY_BIT] && !abort_o && !start_o));
   // R4: an unchanged write is dropped
   a_r4_same_dropped: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && !done_i && ((wdata_i & MASK) | FORCE) == ctrl_q)
         |=> ($stable(ctrl_q) && !start_o && !abort_o));
   // R2/R3: cleared bits stay clear and forced bits stay set
   a_r2_mask_kept: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_q[0] || !ctrl_q[0] |-> (((ctrl_q & ~MASK) == '0) && ((ctrl_q & FORCE) == FORCE)));
   a_r4_one_kind: assert property (@(posedge clk) disable iff (!rst_n)
      !(start_o && abort_o));
endmodule

// File: rtl/dma_flt_store.sv
module dma_flt_store
   import dma_flt_pkg::*;
#(
   parameter int unsigned NCH = 7,
   parameter int unsigned CHW = 3
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic                   ch_hit,
   input  logic [CHW-1:0]         ch_idx,
   input  slot_e                  slot,
   input  logic                   en_hit,
   input  logic [DW-1:0]          wdata,
   output logic [NCH-1:0][DW-1:0] adr_o,
   output logic [NCH-1:0][DW-1:0] len_o,
   output logic [DW-1:0]          en_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         adr_o <= '0;
         len_o <= '0;
         en_o  <= '0;
      end else if (wr_en) begin
         if (en_hit)
            en_o <= wdata;
         if (ch_hit && slot == SLOT_ADR)
            adr_o[ch_idx] <= wdata;
         if (ch_hit && slot == SLOT_LEN)
            len_o[ch_idx] <= wdata;
      end
   end

   // R10: side words never change without a write
   a_r10_enable_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(wr_en) |-> $stable(en_o));
endmodule

// File: rtl/dma_ctl_filter.sv
module dma_ctl_filter
   import dma_flt_pkg::*;
#(
   parameter int unsigned NCH       = 7,
   parameter int unsigned FORCED_CH = 6,
   parameter int unsigned AW        = 8,
   parameter logic [AW-1:0] BASE    = 8'h80,
   parameter logic [AW-1:0] EN_ADDR = 8'hF0
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           wr_en,
   input  logic [AW-1:0]  wr_addr,
   input  logic [31:0]    wr_data,
   input  logic [AW-1:0]  rd_addr,
   output logic [31:0]    rd_data,
   input  logic [NCH-1:0] done,
   output logic [NCH-1:0] start_req,
   output logic [NCH-1:0] abort_req
);
   localparam int unsigned CHW = (NCH > 1) ? $clog2(NCH) : 1;

   if (NCH < 1 || 4 * NCH > DW) begin : g_bad_nch
      $error("channel count must fit the enable word");
   end
   if (FORCED_CH >= NCH) begin : g_bad_forced
      $error("forced channel outside channel range");
   end

   logic           w_ch_hit, w_en_hit, r_ch_hit, r_en_hit;
   logic [CHW-1:0] w_ch, r_ch;
   slot_e          w_slot, r_slot;

   dma_flt_decode #(.AW(AW), .NCH(NCH), .CHW(CHW), .BASE(BASE), .EN_ADDR(EN_ADDR)) u_wdec (
      .addr(wr_addr), .ch_hit(w_ch_hit), .ch_idx(w_ch), .slot(w_slot), .en_hit(w_en_hit));
   dma_flt_decode #(.AW(AW), .NCH(NCH), .CHW(CHW), .BASE(BASE), .EN_ADDR(EN_ADDR)) u_rdec (
      .addr(rd_addr), .ch_hit(r_ch_hit), .ch_idx(r_ch), .slot(r_slot), .en_hit(r_en_hit));

   logic [NCH-1:0][DW-1:0] adr_w, len_w, ctrl_w;
   logic [DW-1:0]          en_w;

   dma_flt_store #(.NCH(NCH), .CHW(CHW)) u_store (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .ch_hit(w_ch_hit), .ch_idx(w_ch),
      .slot(w_slot), .en_hit(w_en_hit), .wdata(wr_data),
      .adr_o(adr_w), .len_o(len_w), .en_o(en_w));

   logic ctl_wr;
   assign ctl_wr = wr_en && w_ch_hit && (w_slot == SLOT_CTL || w_slot == SLOT_CTLB);

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      logic sel;
      assign sel = ctl_wr && (w_ch == CHW'(i));
      if (i == FORCED_CH) begin : g_forced
         dma_flt_chan #(.MASK(FRC_MASK), .FORCE(FRC_SET)) u_chan (
            .clk(clk), .rst_n(rst_n), .wr_i(sel), .wdata_i(wr_data),
            .en_i(en_w[4*i+3]), .done_i(done[i]), .ctrl_o(ctrl_w[i]),
            .start_o(start_req[i]), .abort_o(abort_req[i]));
      end else begin : g_plain
         dma_flt_chan #(.MASK(STD_MASK), .FORCE(NO_SET)) u_chan (
            .clk(clk), .rst_n(rst_n), .wr_i(sel), .wdata_i(wr_data),
            .en_i(en_w[4*i+3]), .done_i(done[i]), .ctrl_o(ctrl_w[i]),
            .start_o(start_req[i]), .abort_o(abort_req[i]));
      end
   end

   always_comb begin
      rd_data = '0;
      if (r_en_hit)
         rd_data = en_w;
      else if (r_ch_hit) begin
         unique case (r_slot)
            SLOT_ADR:  rd_data = adr_w[r_ch];
            SLOT_LEN:  rd_data = len_w[r_ch];
            default:   rd_data = ctrl_w[r_ch];
         endcase
      end
   end

   // R5: at most one channel starts per cycle, since one write reaches one channel
   a_r5_single_start: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(start_req));
   a_r7_single_abort: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(abort_req));
endmodule

// File: tb/sim_dma_ctl_filter.sv
module sim_dma_ctl_filter;
   localparam int CLK_NS = 10;
   localparam int NCH = 7;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [7:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [7:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic [6:0]  done = '0;
   logic [6:0]  start_req, abort_req;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   logic [31:0] m_ctl [NCH];
   logic [31:0] m_adr [NCH];
   logic [31:0] m_len [NCH];
   logic [31:0] m_en;

   always #(CLK_NS/2) clk = ~clk;

   dma_ctl_filter u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .done(done),
      .start_req(start_req), .abort_req(abort_req));

   function automatic logic [31:0] filt(int ch, logic [31:0] d);
      if (ch == 6) return (d & 32'h5100_0002) | 32'h2;
      return d & 32'h7177_0703;
   endfunction

   function automatic logic [7:0] ctl_a(int ch, bit alt);
      return 8'(8'h80 + 16 * ch + (alt ? 12 : 8));
   endfunction

   task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
      rd_addr = a;
      #1;
      checks++;
      if (rd_data !== exp) begin
         errors++;
         $display("FAIL %s read %h got %h exp %h", tag, a, rd_data, exp);
      end
   endtask

   task automatic op(input logic we, input logic [7:0] a, input logic [31:0] d,
                     input logic [6:0] dn, input string tag);
      logic [6:0] es = '0, ea = '0, chg = '0;
      logic [31:0] nv = '0;
      int ch = 0;
      bit side = 0;
      if (we && a >= 8'h80 && a < 8'hF0 && a[1:0] == 2'b00) begin
         ch = int'(a - 8'h80) >> 4;
         side = !a[3];
         if (a[3]) begin
            nv = filt(ch, d);
            if (nv != m_ctl[ch]) begin
               chg[ch] = 1'b1;
               if (!m_ctl[ch][24] && nv[24] && m_en[4*ch+3]) es[ch] = 1'b1;
               if (m_ctl[ch][24] && !nv[24]) ea[ch] = 1'b1;
            end
         end
      end
      @(negedge clk);
      wr_en = we; wr_addr = a; wr_data = d; done = dn;
      @(negedge clk);
      wr_en = 1'b0; done = '0;
      checks++;
      if (start_req !== es || abort_req !== ea) begin
         errors++;
         $display("FAIL %s start %b exp %b abort %b exp %b", tag, start_req, es, abort_req, ea);
      end
      for (int i = 0; i < NCH; i++) begin
         if (chg[i]) m_ctl[i] = nv;
         else if (dn[i]) m_ctl[i][24] = 1'b0;
      end
      if (we && a == 8'hF0) m_en = d;
      if (we && side && !a[2]) m_adr[ch] = d;
      if (we && side && a[2]) m_len[ch] = d;
      for (int i = 0; i < NCH; i++) rd_chk(ctl_a(i, 1'(i % 2)), m_ctl[i], tag);
      rd_chk(8'hF0, m_en, tag);
      if (we && side) rd_chk(a, a[2] ? m_len[ch] : m_adr[ch], tag);
   endtask

   initial begin
      #(CLK_NS * 190000);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      for (int i = 0; i < NCH; i++) begin
         m_ctl[i] = (i == 6) ? 32'h2 : 32'h0;
         m_adr[i] = '0;
         m_len[i] = '0;
      end
      m_en = '0;
      repeat (3) @(negedge clk);
      // R1: reset state
      checks++;
      if (start_req !== '0 || abort_req !== '0) begin
         errors++;
         $display("FAIL R1 pulses during reset %b %b exp 0", start_req, abort_req);
      end
      rst_n = 1'b1;
      @(negedge clk);
      for (int i = 0; i < NCH; i++) begin
         rd_chk(ctl_a(i, 0), m_ctl[i], "R1");
         rd_chk(8'(8'h80 + 16 * i), 32'h0, "R1");
         @(negedge clk);
      end
      rd_chk(8'hF0, 32'h0, "R1");

      // R2/R6: all ones on channel 0 with enable clear
      op(1, ctl_a(0, 0), 32'hFFFF_FFFF, '0, "R6");
      rd_chk(ctl_a(0, 0), 32'h7177_0703, "R2");
      // R6: enabling afterwards raises nothing
      op(1, 8'hF0, 32'hFFFF_FFFF, '0, "R10");
      // R7: busy falls by write
      op(1, ctl_a(0, 0), 32'h0, '0, "R7");
      // R5/R8: busy rises through the second control offset
      op(1, ctl_a(0, 1), 32'h0100_0000, '0, "R8");
      // R3: forced channel
      op(1, ctl_a(6, 0), 32'hFFFF_FFFF, '0, "R3");
      rd_chk(ctl_a(6, 0), 32'h5100_0002, "R3");
      // R4: same value with junk in cleared bits
      op(1, ctl_a(6, 1), 32'h5100_0002 | 32'hAEFF_FFFD, '0, "R4");
      // R9: done clears busy quietly
      op(0, 8'h00, 32'h0, 7'b100_0000, "R9");
      // R11: changing write meets done
      op(1, ctl_a(2, 0), 32'h0100_0000, 7'b000_0100, "R11");
      // R10: side words
      op(1, 8'h94, 32'hDEAD_BEEF, '0, "R10");
      op(1, 8'hE0, 32'h1234_5678, '0, "R10");
      // R6: rise with enable bit of channel 3 cleared
      op(1, 8'hF0, 32'hFFFF_7FFF, '0, "R10");
      op(1, ctl_a(3, 0), 32'h0100_0001, '0, "R6");

      for (int n = 0; n < 600; n++) begin
         int k = int'($urandom % 10);
         int ch = int'($urandom % NCH);
         int r = int'($urandom % 4);
         logic [31:0] d = $urandom;
         bit alt = 1'($urandom % 2);
         if (r == 1) d = m_ctl[ch] | ~(ch == 6 ? 32'h5100_0002 : 32'h7177_0703);
         else if (r == 2) d = m_ctl[ch] ^ 32'h0100_0000;
         else if (r == 3) d = d | 32'h0100_0000;
         if (k < 5)       op(1, ctl_a(ch, alt), d, '0, "R5");
         else if (k == 5) op(0, 8'h00, 32'h0, 7'($urandom), "R9");
         else if (k == 6) op(1, 8'hF0, $urandom, '0, "R10");
         else if (k == 7) op(1, 8'(8'h80 + 16 * ch), d, '0, "R10");
         else if (k == 8) op(1, 8'(8'h84 + 16 * ch), d, '0, "R10");
         else             op(1, ctl_a(ch, alt), d, 7'(1 << ch), "R11");
      end

      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule